// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block arbitrates six interrupt sources for a small 8-bit processor core. Three byte-wide registers on a simple register bus hold its configuration:
- a mask register, with one enable bit per source and a master enable in bit 7;
- a priority low plane;
- a priority high plane.

Each source reads one bit from each priority plane. The pair of bits places that source on one of four levels. The request flags come from the timers, the serial port and the external-pin edge logic, which all sit outside this block.

Every cycle the block looks at the flags it can serve. It picks the best one: the highest level first, then the fixed polling order within a level. It raises a vector request that carries the vector address of the chosen source. When the core acknowledges, the block records the winning level in a one-bit-per-level in-service vector. In that same cycle it pulses a clear strobe for flags that hardware must clear. A return pulse retires the highest level in service. That resumes whatever lower-level handler was interrupted. Only a strictly higher level can interrupt a running handler.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all three registers read 0, `vec_req` is 0, `svc_level` is 0 and every source is masked.
- R2: Writes with `sfr_wr` high load the mask register at address 0xA8, the low priority plane at 0xB8 and the high priority plane at 0xB7. `sfr_rdata` returns the addressed register combinationally. Bit 6 of the mask register reads 0, bits 7:6 of both priority planes read 0, and any other address reads 0.
- R3: A source is a candidate only if its flag is set, its enable bit is 1 and bit 7 of the mask register is 1. Source bit positions 0 to 5 are: external 0, timer 0, external 1, timer 1, serial, timer 2.
- R4: The level of source i is the 2-bit value {high[i], low[i]}, where 3 is the most urgent. The winner is always a candidate at the highest level present.
- R5: Among candidates at the same level, the lowest bit position wins.
- R6: While `vec_req` is 1, `vec_addr` equals 0x0003 + 8 × (winner's bit position).
- R7: When any level is in service, only candidates with a level strictly above the highest in-service level can raise `vec_req`.
- R8: An acknowledge while `vec_req` is 1 sets the winner's level bit in `svc_level` at the next edge. An acknowledge while `vec_req` is 0 has no effect.
- R9: A return pulse clears the highest set bit of `svc_level` at the next edge. The lower levels stay set, so a preempted lower level becomes current again.
- R10: In the acknowledge cycle, `flag_clr` pulses the winner's bit in two cases: the winner is timer 0 or timer 1, or the winner is external 0 or external 1 and its `ext_edge` bit (bit 0 for external 0, bit 1 for external 1) is 1. Serial, timer 2 and level-mode external winners are never cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data for `sfr_addr` |
| req_flags | input | 6 | Latched request flags, one per source |
| ext_edge | input | 2 | Transition-mode select for external 0 (bit 0) and external 1 (bit 1) |
| vec_req | output | 1 | A request is ready for the core |
| vec_addr | output | 16 | Vector address of the winning source |
| vec_ack | input | 1 | One-cycle acknowledge from the core |
| reti | input | 1 | One-cycle return-from-handler pulse |
| flag_clr | output | 6 | Hardware clear strobe for request flags |
| svc_level | output | 4 | In-service levels, one bit per level |

## Verification
The assertions assume three things about the core. It acknowledges only while `vec_req` is high. It never raises the return pulse in the same cycle as an acknowledge. It returns only while some level is in service.

The bench computes every acknowledge and return decision from its own model before driving it, so the stimulus stays within these rules. The request flags behave like flag sources outside the block: once set, a flag stays set until its `flag_clr` strobe arrives.

Random register writes reshuffle levels and masks while handlers are nested. This exercises preemption and resumption at every depth.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int LVL_W   = 2;
   localparam int NUM_LVL = 1 << LVL_W;
   typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
   parameter int         N_SRC = 6,
   parameter logic [7:0] A_EN  = 8'hA8,
   parameter logic [7:0] A_PLO = 8'hB8,
   parameter logic [7:0] A_PHI = 8'hB7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr,
   input  logic [7:0]       addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output logic [N_SRC-1:0] en,
   output logic [N_SRC-1:0] plo,
   output logic [N_SRC-1:0] phi,
   output logic             glob
);
   localparam int GLOB_BIT = 7;

   always_ff @(posedge clk) begin
      if (rst) begin
         en   <= '0;
         plo  <= '0;
         phi  <= '0;
         glob <= 1'b0;
      end else if (wr) begin
         if (addr == A_EN) begin
            en   <= wdata[N_SRC-1:0];
            glob <= wdata[GLOB_BIT];
         end
         if (addr == A_PLO) plo <= wdata[N_SRC-1:0];
         if (addr == A_PHI) phi <= wdata[N_SRC-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_EN) begin
         rdata[N_SRC-1:0] = en;
         rdata[GLOB_BIT]  = glob;
      end else if (addr == A_PLO) begin
         rdata[N_SRC-1:0] = plo;
      end else if (addr == A_PHI) begin
         rdata[N_SRC-1:0] = phi;
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int N_SRC      = 6,
   parameter int VEC_W      = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8
) (
   input  logic [N_SRC-1:0] flags,
   input  logic [N_SRC-1:0] en,
   input  logic [N_SRC-1:0] plo,
   input  logic [N_SRC-1:0] phi,
   input  logic             glob,
   input  logic             cur_valid,
   input  lvl_t             cur_lvl,
   output logic             req,
   output logic [N_SRC-1:0] sel_oh,
   output lvl_t             sel_lvl,
   output logic [VEC_W-1:0] vec
);
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   lvl_t             src_lvl [N_SRC];
   logic [N_SRC-1:0] elig;
   logic [N_SRC-1:0] lvl_mask [NUM_LVL];
   logic [N_SRC-1:0] win_mask;
   logic [IDX_W-1:0] sel_idx;

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      assign src_lvl[g] = {phi[g], plo[g]};
      assign elig[g]    = glob & en[g] & flags[g] & (~cur_valid | (src_lvl[g] > cur_lvl));
      for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
         assign lvl_mask[l][g] = elig[g] & (src_lvl[g] == lvl_t'(l));
      end
   end

   always_comb begin
      req      = 1'b0;
      sel_lvl  = '0;
      win_mask = '0;
      for (int l = NUM_LVL - 1; l >= 0; l--) begin
         if (!req && (|lvl_mask[l])) begin
            req      = 1'b1;
            sel_lvl  = lvl_t'(l);
            win_mask = lvl_mask[l];
         end
      end
   end

   assign sel_oh = win_mask & (~win_mask + N_SRC'(1));

   always_comb begin
      sel_idx = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (sel_oh[i]) sel_idx = IDX_W'(i);
      end
   end

   assign vec = VEC_W'(VEC_BASE) + VEC_W'(sel_idx) * VEC_W'(VEC_STRIDE);
endmodule

// File: rtl/irq_nest.sv
module irq_nest
   import irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst,
   input  logic               push,
   input  lvl_t               push_lvl,
   input  logic               pop,
   output logic [NUM_LVL-1:0] isv,
   output logic               cur_valid,
   output lvl_t               cur_lvl
);
   logic [NUM_LVL-1:0] top_oh;
   logic [NUM_LVL-1:0] set_oh;

   always_comb begin
      cur_lvl = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (isv[l]) cur_lvl = lvl_t'(l);
      end
   end

   assign cur_valid = |isv;
   assign top_oh    = (pop && cur_valid) ? (NUM_LVL'(1) << cur_lvl) : '0;
   assign set_oh    = push ? (NUM_LVL'(1) << push_lvl) : '0;

   always_ff @(posedge clk) begin
      if (rst) isv <= '0;
      else     isv <= (isv & ~top_oh) | set_oh;
   end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
   import irq_pkg::*;
#(
   parameter int         N_SRC       = 6,
   parameter int         VEC_W       = 16,
   parameter int         VEC_BASE    = 3,
   parameter int         VEC_STRIDE  = 8,
   parameter int         EXT0_IDX    = 0,
   parameter int         EXT1_IDX    = 2,
   parameter logic [7:0] HW_CLR_MASK = 8'b0000_1010,
   parameter logic [7:0] A_EN        = 8'hA8,
   parameter logic [7:0] A_PLO       = 8'hB8,
   parameter logic [7:0] A_PHI       = 8'hB7
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sfr_wr,
   input  logic [7:0]         sfr_addr,
   input  logic [7:0]         sfr_wdata,
   output logic [7:0]         sfr_rdata,
   input  logic [N_SRC-1:0]   req_flags,
   input  logic [1:0]         ext_edge,
   output logic               vec_req,
   output logic [VEC_W-1:0]   vec_addr,
   input  logic               vec_ack,
   input  logic               reti,
   output logic [N_SRC-1:0]   flag_clr,
   output logic [NUM_LVL-1:0] svc_level
);
   if (N_SRC < 1 || N_SRC > 7) begin : g_bad_nsrc
      $error("N_SRC must fit below the master enable bit");
   end
   if (VEC_W < 8 || VEC_BASE + (N_SRC - 1) * VEC_STRIDE >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector table does not fit in VEC_W bits");
   end
   if (EXT0_IDX >= N_SRC || EXT1_IDX >= N_SRC || EXT0_IDX == EXT1_IDX) begin : g_bad_ext
      $error("external source indices out of range");
   end

   logic [N_SRC-1:0] en, plo, phi, sel_oh, clr_en;
   logic             glob_en, cur_valid, take;
   lvl_t             sel_lvl, cur_lvl;

   irq_regs #(.N_SRC(N_SRC), .A_EN(A_EN), .A_PLO(A_PLO), .A_PHI(A_PHI)) u_regs (
      .clk(clk), .rst(rst), .wr(sfr_wr), .addr(sfr_addr), .wdata(sfr_wdata),
      .rdata(sfr_rdata), .en(en), .plo(plo), .phi(phi), .glob(glob_en)
   );

   irq_arbiter #(.N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
                 .VEC_STRIDE(VEC_STRIDE)) u_arb (
      .flags(req_flags), .en(en), .plo(plo), .phi(phi), .glob(glob_en),
      .cur_valid(cur_valid), .cur_lvl(cur_lvl), .req(vec_req),
      .sel_oh(sel_oh), .sel_lvl(sel_lvl), .vec(vec_addr)
   );

   assign take = vec_ack & vec_req;

   irq_nest u_nest (
      .clk(clk), .rst(rst), .push(take), .push_lvl(sel_lvl), .pop(reti),
      .isv(svc_level), .cur_valid(cur_valid), .cur_lvl(cur_lvl)
   );

   for (genvar g = 0; g < N_SRC; g++) begin : g_clr
      if (g == EXT0_IDX) begin : g_ext0
         assign clr_en[g] = ext_edge[0];
      end else if (g == EXT1_IDX) begin : g_ext1
         assign clr_en[g] = ext_edge[1];
      end else begin : g_fixed
         assign clr_en[g] = HW_CLR_MASK[g];
      end
   end

   assign flag_clr = take ? (sel_oh & clr_en) : '0;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
   import irq_pkg::*;
#(
   parameter int N_SRC      = 6,
   parameter int VEC_W      = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               vec_req,
   input logic               vec_ack,
   input logic               reti,
   input logic [VEC_W-1:0]   vec_addr,
   input logic [N_SRC-1:0]   flag_clr,
   input logic [NUM_LVL-1:0] svc_level,
   input logic               glob_en,
   input lvl_t               sel_lvl,
   input logic               cur_valid,
   input lvl_t               cur_lvl
);
   AST_MASTER_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
      !glob_en |-> !vec_req); // R3
   AST_ONLY_HIGHER: assert property (@(posedge clk) disable iff (rst)
      (vec_req && cur_valid) |-> (sel_lvl > cur_lvl)); // R7
   AST_VEC_ON_GRID: assert property (@(posedge clk) disable iff (rst)
      vec_req |-> (((int'(vec_addr) - VEC_BASE) % VEC_STRIDE) == 0)); // R6
   AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (rst)
      (vec_ack && vec_req) |=> svc_level[$past(sel_lvl)]); // R8
   AST_RETURN_POPS_ONE: assert property (@(posedge clk) disable iff (rst)
      (reti && !vec_ack && svc_level != '0) |=>
         ($countones(svc_level) == $countones($past(svc_level)) - 1)); // R9
   AST_CLR_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
      (flag_clr != '0) |-> (vec_ack && vec_req)); // R10
   AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(flag_clr)); // R10
endmodule

bind nested_irq_ctrl irq_ctrl_chk #(
   .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
   .clk(clk), .rst(rst), .vec_req(vec_req), .vec_ack(vec_ack), .reti(reti),
   .vec_addr(vec_addr), .flag_clr(flag_clr), .svc_level(svc_level),
   .glob_en(glob_en), .sel_lvl(sel_lvl), .cur_valid(cur_valid), .cur_lvl(cur_lvl)
);

// File: tb/tb_nested_irq_ctrl.sv
module tb_nested_irq_ctrl;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst = 1'b1, sfr_wr = 1'b0, vec_ack = 1'b0, reti = 1'b0;
   logic [7:0]  sfr_addr = 8'h00, sfr_wdata = 8'h00;
   logic [5:0]  req_flags = 6'h00;
   logic [1:0]  ext_edge = 2'b00;
   wire  [7:0]  sfr_rdata;
   wire         vec_req;
   wire  [15:0] vec_addr;
   wire  [5:0]  flag_clr;
   wire  [3:0]  svc_level;

   nested_irq_ctrl dut (
      .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .req_flags(req_flags),
      .ext_edge(ext_edge), .vec_req(vec_req), .vec_addr(vec_addr),
      .vec_ack(vec_ack), .reti(reti), .flag_clr(flag_clr), .svc_level(svc_level)
   );

   int errs = 0, checks = 0;
   bit done = 1'b0;

   // reference state
   logic [7:0] m_en = 8'h00, m_plo = 8'h00, m_phi = 8'h00;
   logic [3:0] m_isv = 4'h0;
   logic       e_req;
   logic [5:0] e_clr;
   int         e_idx, e_lvl;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void model_eval();
      int cur = -1;
      for (int l = 0; l < 4; l++) if (m_isv[l]) cur = l;
      e_req = 1'b0; e_lvl = -1; e_idx = 0; e_clr = 6'h00;
      for (int i = 0; i < 6; i++) begin
         int lv = 2 * int'(m_phi[i]) + int'(m_plo[i]);
         if (m_en[7] && m_en[i] && req_flags[i] && lv > cur && lv > e_lvl) begin
            e_req = 1'b1; e_lvl = lv; e_idx = i;
         end
      end
      if (vec_ack && e_req) begin
         if (e_idx == 1 || e_idx == 3) e_clr[e_idx] = 1'b1;
         if (e_idx == 0 && ext_edge[0]) e_clr[0] = 1'b1;
         if (e_idx == 2 && ext_edge[1]) e_clr[2] = 1'b1;
      end
   endfunction

   function automatic logic [7:0] exp_rd(logic [7:0] a);
      if (a == 8'hA8) return m_en;
      if (a == 8'hB8) return m_plo;
      if (a == 8'hB7) return m_phi;
      return 8'h00;
   endfunction

   // one clock: compare at negedge+1, update model at posedge, return at negedge
   task automatic tick();
      logic [5:0] pend;
      #1;
      model_eval();
      chk("R7 vec_req", 32'(vec_req), 32'(e_req));
      if (e_req) chk("R6 vec_addr", 32'(vec_addr), 32'(3 + 8 * e_idx));
      chk("R10 flag_clr", 32'(flag_clr), 32'(e_clr));
      chk("R9 svc_level", 32'(svc_level), 32'(m_isv));
      chk("R2 sfr_rdata", 32'(sfr_rdata), 32'(exp_rd(sfr_addr)));
      pend = e_clr;
      @(posedge clk);
      if (sfr_wr) begin
         if (sfr_addr == 8'hA8) m_en  = sfr_wdata & 8'hBF;
         if (sfr_addr == 8'hB8) m_plo = sfr_wdata & 8'h3F;
         if (sfr_addr == 8'hB7) m_phi = sfr_wdata & 8'h3F;
      end
      if (reti) begin
         for (int l = 3; l >= 0; l--) if (m_isv[l]) begin m_isv[l] = 1'b0; break; end
      end
      if (vec_ack && e_req) m_isv[e_lvl] = 1'b1;
      @(negedge clk);
      req_flags = req_flags & ~pend;
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
      tick();
      sfr_wr = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errs++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      foreach (sfr_addr[i]) ; // no-op
      sfr_addr = 8'hA8; #1; chk("R1 mask after reset", 32'(sfr_rdata), 0);
      sfr_addr = 8'hB8; #0; chk("R1 low plane after reset", 32'(sfr_rdata), 0);
      chk("R1 vec_req after reset", 32'(vec_req), 0);
      chk("R1 svc_level after reset", 32'(svc_level), 0);
      @(negedge clk);

      // R3 master enable off masks all
      req_flags = 6'h3F;
      wr(8'hA8, 8'h3F);
      chk("R3 master off", 32'(vec_req), 0);
      wr(8'hA8, 8'hFF);
      sfr_addr = 8'hA8; tick();
      chk("R2 mask readback bit6 zero", 32'(sfr_rdata), 32'h BF);
      chk("R5 tie picks external 0", 32'(vec_addr), 32'h03);
      // R4 higher level wins
      wr(8'hB7, 8'h10);
      chk("R4 serial at level 2", 32'(vec_addr), 32'h23);
      wr(8'hB8, 8'hFF);
      sfr_addr = 8'hB8; tick();
      chk("R2 low plane readback", 32'(sfr_rdata), 32'h3F);
      // R8 acknowledge
      vec_ack = 1'b1; tick(); vec_ack = 1'b0;
      chk("R8 level 3 in service", 32'(svc_level), 32'h8);
      chk("R7 nothing above level 3", 32'(vec_req), 0);
      reti = 1'b1; tick(); reti = 1'b0;
      chk("R9 return empties", 32'(svc_level), 0);

      // nesting: all level 0, external 0 edge mode
      wr(8'hB7, 8'h00); wr(8'hB8, 8'h00);
      req_flags = 6'h01; ext_edge = 2'b01; tick();
      vec_ack = 1'b1; #1; chk("R10 edge ext0 cleared", 32'(flag_clr), 32'h01);
      @(negedge clk); vec_ack = 1'b0; #0;
      // replay the model step that was skipped for this cycle
      m_isv[0] = 1'b1; req_flags = 6'h00;
      tick();
      chk("R8 level 0 in service", 32'(svc_level), 32'h1);
      req_flags = 6'h08; wr(8'hB7, 8'h08);
      chk("R7 timer 1 preempts", 32'(vec_addr), 32'h1B);
      vec_ack = 1'b1; tick(); vec_ack = 1'b0;
      chk("R8 nested levels", 32'(svc_level), 32'h5);
      chk("R10 timer 1 flag cleared", 32'(req_flags), 0);
      req_flags = 6'h10; tick();
      chk("R7 equal level waits", 32'(vec_req), 0);
      reti = 1'b1; tick(); reti = 1'b0;
      chk("R9 resume lower", 32'(svc_level), 32'h1);
      reti = 1'b1; tick(); reti = 1'b0;
      req_flags = 6'h00; tick();

      // random phase
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(15) == 0) begin
            logic [7:0] a;
            case ($urandom_range(3))
               0: a = 8'hA8;
               1: a = 8'hB8;
               2: a = 8'hB7;
               default: a = 8'h5A;
            endcase
            sfr_wr = 1'b1; sfr_addr = a;
            sfr_wdata = 8'($urandom) | ((a == 8'hA8) ? 8'h80 : 8'h00);
         end else begin
            sfr_wr = 1'b0;
            sfr_addr = ($urandom_range(1) == 0) ? 8'hA8 : 8'hB7;
         end
         if ($urandom_range(3) == 0) req_flags = req_flags | 6'($urandom);
         if ($urandom_range(31) == 0) ext_edge = 2'($urandom);
         vec_ack = 1'b0;
         model_eval();
         vec_ack = e_req && ($urandom_range(2) == 0);
         reti = !vec_ack && (m_isv != 4'h0) && ($urandom_range(4) == 0);
         tick();
      end
      sfr_wr = 1'b0; vec_ack = 1'b0; reti = 1'b0;
      tick();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule